// File: doc/BRIEF.md
# Per-Bank Open-Row-First Request Scheduler

This block holds pending memory requests for a DRAM controller. Each bank has its own ordered buffer. Each request carries a tag, a bank index and a row address, and new requests are appended behind the older ones of their bank. A bank's state machine queries the block with its bank index and its row state. In the same cycle it receives the request to serve next, a flag saying whether more work waits behind that request, and a flag saying whether a later request wants the same row.

A request stays in its buffer while it is being served. It leaves only when the controller issues its column command, and the removal names the request by tag. The lookahead flags therefore always count the request in service. A parameter selects one of two policies. The open-row-first policy prefers the oldest request that hits the open row. The plain FIFO policy always serves the head.

Top module: `frfcfs_sched`

## Requirements
- R1: A request accepted with `in_valid` and `in_ready` high is appended behind all older requests of the bank named by `in_bank`. The buffers of other banks are untouched.
- R2: When `q_row_open` is low, the offered request (`nxt_tag`, `nxt_row`) is the oldest request of bank `q_bank`.
- R3: In open-row-first mode with `q_row_open` high, the offered request is the oldest one whose row equals `q_row`. If no request matches, the oldest request is offered.
- R4: Offering a request does not remove it. A removal (`rm_valid`, `rm_bank`, `rm_tag`) deletes the entry with that tag from any position and keeps the remaining entries in age order.
- R5: A removal whose tag is not present raises `rm_err` in the same cycle and leaves the buffer unchanged.
- R6: `more_pending` is high exactly when bank `q_bank` holds two or more requests.
- R7: In open-row-first mode, `hit_ahead` is high exactly when two or more requests of bank `q_bank` target row `q_row`.
- R8: With `DEPTH` requests stored in the bank named by `in_bank`, `in_ready` is low. A request offered then is not stored. Other banks still accept requests.
- R9: In FIFO mode (`MODE` = `SCH_FIFO`), the head is always offered. Only the head's tag can be removed, and any other tag raises `rm_err`. `hit_ahead` is high exactly when a second entry exists and its row equals `q_row`.
- R10: An empty bank gives `nxt_valid` low, `more_pending` low and `hit_ahead` low.
- R11: An insert and a removal on the same bank in the same cycle are both carried out. The new request lands behind the survivors.
- R12: After reset, every bank is empty and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New request offered |
| in_ready | output | 1 | Bank `in_bank` has room |
| in_bank | input | BANK_W | Bank of the new request |
| in_tag | input | TAG_W | Tag of the new request |
| in_row | input | ROW_W | Row of the new request |
| rm_valid | input | 1 | Column command issued: remove a request |
| rm_bank | input | BANK_W | Bank of the removal |
| rm_tag | input | TAG_W | Tag to remove |
| rm_err | output | 1 | Removal tag is not present |
| q_bank | input | BANK_W | Bank being queried |
| q_row_open | input | 1 | Queried bank has a row open |
| q_row | input | ROW_W | Open row, or the row for the lookahead |
| nxt_valid | output | 1 | A request is offered |
| nxt_tag | output | TAG_W | Tag of the offered request |
| nxt_row | output | ROW_W | Row of the offered request |
| more_pending | output | 1 | Two or more requests are held |
| hit_ahead | output | 1 | Row-hit lookahead flag |

## Verification
The bench builds two copies, both with four banks, a depth of four and 4-bit tags and rows. One copy uses the open-row-first policy and the other uses FIFO. Both share the same stimulus, so the same sequence exposes where the two policies differ in selection, removal and lookahead. A depth of four lets a bank fill up in a few cycles, which reaches the back-pressure case and a removal from the middle of a buffer. The small row width makes colliding rows easy to set up.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    SCH_FRFCFS = 1'b0,
    SCH_FIFO   = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/bank_queue.sv
module bank_queue
  import sched_pkg::*;
#(
  parameter int          DEPTH = 4,
  parameter int          TAG_W = 4,
  parameter int          ROW_W = 8,
  parameter sched_mode_e MODE  = SCH_FRFCFS,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [ROW_W-1:0] push_row,
  input  logic             rm_req,
  input  logic [TAG_W-1:0] rm_tag,
  output logic             rm_hit,
  output logic [TAG_W-1:0] ent_tag [DEPTH],
  output logic [ROW_W-1:0] ent_row [DEPTH],
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [ROW_W-1:0] row_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_keep;
  logic [IDX_W-1:0] rm_idx;
  logic             rm_do, upd_en;

  // Oldest matching tag; FIFO mode considers the head only.
  always_comb begin
    rm_hit = 1'b0;
    rm_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!rm_hit && (CNT_W'(i) < cnt_q) && (tag_q[i] == rm_tag) &&
          (MODE == SCH_FRFCFS || i == 0)) begin
        rm_hit = 1'b1;
        rm_idx = IDX_W'(i);
      end
    end
  end

  assign rm_do    = rm_req && rm_hit;
  assign upd_en   = rm_do || push;
  assign cnt_keep = cnt_q - CNT_W'(rm_do);

  // Next state: close the gap, then append at the new tail.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      tag_d[i] = tag_q[i];
      row_d[i] = row_q[i];
    end
    if (rm_do) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= rm_idx) begin
          tag_d[i] = tag_q[i+1];
          row_d[i] = row_q[i+1];
        end
      end
    end
    if (push) begin
      tag_d[cnt_keep[IDX_W-1:0]] = push_tag;
      row_d[cnt_keep[IDX_W-1:0]] = push_row;
    end
    cnt_d = cnt_keep + CNT_W'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= tag_d[i];
        row_q[i] <= row_d[i];
      end
    end
  end

  assign ent_tag = tag_q;
  assign ent_row = row_q;
  assign cnt     = cnt_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rm_do) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  a_r4_remove_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_do && !push) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r5_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_req && !rm_hit && !push) |=> $stable(cnt_q));
  a_r11_swap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_do && push) |=> $stable(cnt_q));

endmodule

// File: rtl/pick_logic.sv
module pick_logic
  import sched_pkg::*;
#(
  parameter int          DEPTH = 4,
  parameter int          TAG_W = 4,
  parameter int          ROW_W = 8,
  parameter sched_mode_e MODE  = SCH_FRFCFS,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] ent_tag [DEPTH],
  input  logic [ROW_W-1:0] ent_row [DEPTH],
  input  logic [CNT_W-1:0] cnt,
  input  logic             row_open,
  input  logic [ROW_W-1:0] q_row,
  output logic             nxt_valid,
  output logic [TAG_W-1:0] nxt_tag,
  output logic [ROW_W-1:0] nxt_row,
  output logic             more_pending,
  output logic             hit_ahead
);

  logic [DEPTH-1:0] hit;
  logic [IDX_W-1:0] sel;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit[i] = (CNT_W'(i) < cnt) && (ent_row[i] == q_row);
  end

  generate
    if (MODE == SCH_FRFCFS) begin : g_open_row_first
      logic             any_hit;
      logic [IDX_W-1:0] first_hit;
      logic [CNT_W-1:0] n_hit;

      // Age-ordered priority encoder: lowest index is oldest.
      always_comb begin
        any_hit   = 1'b0;
        first_hit = '0;
        n_hit     = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (hit[i]) begin
            n_hit = n_hit + CNT_W'(1);
            if (!any_hit) begin
              any_hit   = 1'b1;
              first_hit = IDX_W'(i);
            end
          end
        end
      end

      assign sel       = (row_open && any_hit) ? first_hit : '0;
      assign hit_ahead = (n_hit >= CNT_W'(2));

      a_r3_open_hit_served: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open && hit_ahead) |-> (nxt_row == q_row));
    end else begin : g_fifo
      assign sel       = '0;
      assign hit_ahead = hit[1];
    end
  endgenerate

  assign nxt_valid    = (cnt != '0);
  assign nxt_tag      = ent_tag[sel];
  assign nxt_row      = ent_row[sel];
  assign more_pending = (cnt >= CNT_W'(2));

  a_r6_more_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
    more_pending |-> nxt_valid);
  a_r10_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_valid |-> (!hit_ahead && !more_pending));

endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import sched_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter int          DEPTH     = 4,
  parameter int          TAG_W     = 4,
  parameter int          ROW_W     = 8,
  parameter sched_mode_e MODE      = SCH_FRFCFS,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [ROW_W-1:0]  in_row,
  input  logic              rm_valid,
  input  logic [BANK_W-1:0] rm_bank,
  input  logic [TAG_W-1:0]  rm_tag,
  output logic              rm_err,
  input  logic [BANK_W-1:0] q_bank,
  input  logic              q_row_open,
  input  logic [ROW_W-1:0]  q_row,
  output logic              nxt_valid,
  output logic [TAG_W-1:0]  nxt_tag,
  output logic [ROW_W-1:0]  nxt_row,
  output logic              more_pending,
  output logic              hit_ahead
);

  logic [TAG_W-1:0]     all_tag [NUM_BANKS][DEPTH];
  logic [ROW_W-1:0]     all_row [NUM_BANKS][DEPTH];
  logic [CNT_W-1:0]     all_cnt [NUM_BANKS];
  logic [NUM_BANKS-1:0] full_v, found_v;
  logic                 accept;

  assign in_ready = !full_v[in_bank];
  assign accept   = in_valid && in_ready;
  assign rm_err   = rm_valid && !found_v[rm_bank];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic push_b, rm_b;
      assign push_b = accept && (in_bank == BANK_W'(b));
      assign rm_b   = rm_valid && (rm_bank == BANK_W'(b));

      bank_queue #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .ROW_W(ROW_W), .MODE(MODE)
      ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_b),
        .push_tag (in_tag),
        .push_row (in_row),
        .rm_req   (rm_b),
        .rm_tag   (rm_tag),
        .rm_hit   (found_v[b]),
        .ent_tag  (all_tag[b]),
        .ent_row  (all_row[b]),
        .cnt      (all_cnt[b]),
        .full     (full_v[b])
      );
    end
  endgenerate

  pick_logic #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .ROW_W(ROW_W), .MODE(MODE)
  ) u_pick (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_tag      (all_tag[q_bank]),
    .ent_row      (all_row[q_bank]),
    .cnt          (all_cnt[q_bank]),
    .row_open     (q_row_open),
    .q_row        (q_row),
    .nxt_valid    (nxt_valid),
    .nxt_tag      (nxt_tag),
    .nxt_row      (nxt_row),
    .more_pending (more_pending),
    .hit_ahead    (hit_ahead)
  );

  a_r5_err_only_on_remove: assert property (@(posedge clk) disable iff (!rst_n)
    rm_err |-> rm_valid);
  a_r8_ready_when_room: assert property (@(posedge clk) disable iff (!rst_n)
    (all_cnt[in_bank] < CNT_W'(DEPTH)) |-> in_ready);

endmodule

// File: tb/frfcfs_sched_test.sv
module frfcfs_sched_test;
  import sched_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, rm_valid = 1'b0, q_row_open = 1'b0;
  logic [1:0] in_bank = '0, rm_bank = '0, q_bank = '0;
  logic [3:0] in_tag = '0, in_row = '0, rm_tag = '0, q_row = '0;

  logic       in_ready, rm_err, nxt_valid, more_pending, hit_ahead;
  logic [3:0] nxt_tag, nxt_row;
  logic       f_in_ready, f_rm_err, f_nxt_valid, f_more, f_hit;
  logic [3:0] f_nxt_tag, f_nxt_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  frfcfs_sched #(.NUM_BANKS(4), .DEPTH(4), .TAG_W(4), .ROW_W(4), .MODE(SCH_FRFCFS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_tag(in_tag), .in_row(in_row),
    .rm_valid(rm_valid), .rm_bank(rm_bank), .rm_tag(rm_tag), .rm_err(rm_err),
    .q_bank(q_bank), .q_row_open(q_row_open), .q_row(q_row),
    .nxt_valid(nxt_valid), .nxt_tag(nxt_tag), .nxt_row(nxt_row),
    .more_pending(more_pending), .hit_ahead(hit_ahead));

  frfcfs_sched #(.NUM_BANKS(4), .DEPTH(4), .TAG_W(4), .ROW_W(4), .MODE(SCH_FIFO)) uut_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_in_ready),
    .in_bank(in_bank), .in_tag(in_tag), .in_row(in_row),
    .rm_valid(rm_valid), .rm_bank(rm_bank), .rm_tag(rm_tag), .rm_err(f_rm_err),
    .q_bank(q_bank), .q_row_open(q_row_open), .q_row(q_row),
    .nxt_valid(f_nxt_valid), .nxt_tag(f_nxt_tag), .nxt_row(f_nxt_row),
    .more_pending(f_more), .hit_ahead(f_hit));

  // Query vectors: bank, row_open, row | exp valid, tag, more, hit
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {2'd1, 1'b0, 4'd3, 1'b1, 4'd1, 1'b1, 1'b1},
    {2'd1, 1'b1, 4'd5, 1'b1, 4'd2, 1'b1, 1'b0},
    {2'd1, 1'b1, 4'd3, 1'b1, 4'd1, 1'b1, 1'b1},
    {2'd1, 1'b1, 4'd7, 1'b1, 4'd4, 1'b1, 1'b0},
    {2'd1, 1'b1, 4'd9, 1'b1, 4'd1, 1'b1, 1'b0},
    {2'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] b, input logic [3:0] t, input logic [3:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_bank = b; in_tag = t; in_row = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic remove(input logic [1:0] b, input logic [3:0] t);
    @(negedge clk);
    rm_valid = 1'b1; rm_bank = b; rm_tag = t;
    @(negedge clk);
    rm_valid = 1'b0;
  endtask

  task automatic query(input logic [1:0] b, input logic o, input logic [3:0] r);
    q_bank = b; q_row_open = o; q_row = r;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R10: reset state
    in_bank = 2'd1;
    query(2'd1, 1'b0, 4'd0);
    check("R12 in_ready after reset", in_ready, 1);
    check("R12 empty after reset", nxt_valid, 0);
    check("R10 empty more_pending", more_pending, 0);

    // R1: fill bank 1 in age order
    push(2'd1, 4'd1, 4'd3);
    push(2'd1, 4'd2, 4'd5);
    push(2'd1, 4'd3, 4'd3);
    push(2'd1, 4'd4, 4'd7);

    // R2 R3 R6 R7 R10: table of query vectors
    for (int v = 0; v < NV; v++) begin
      query(VEC[v][13:12], VEC[v][11], VEC[v][10:7]);
      check("R2_R3_R10 nxt_valid", nxt_valid, VEC[v][6]);
      if (VEC[v][6]) check("R2_R3 nxt_tag", nxt_tag, VEC[v][5:2]);
      check("R6 more_pending", more_pending, VEC[v][1]);
      check("R7 hit_ahead", hit_ahead, VEC[v][0]);
    end
    query(2'd1, 1'b0, 4'd0);
    check("R4 offer keeps entry", nxt_tag, 1);

    // R4: remove from the middle
    remove(2'd1, 4'd3);
    query(2'd1, 1'b1, 4'd3);
    check("R4 middle removed tag", nxt_tag, 1);
    check("R7 single row match", hit_ahead, 0);
    query(2'd1, 1'b1, 4'd7);
    check("R4 order kept", nxt_tag, 4);

    // R5: absent tag
    @(negedge clk);
    rm_valid = 1'b1; rm_bank = 2'd1; rm_tag = 4'd9;
    #1;
    check("R5 rm_err on absent tag", rm_err, 1);
    @(negedge clk);
    rm_valid = 1'b0;
    query(2'd1, 1'b0, 4'd3);
    check("R5 buffer unchanged head", nxt_tag, 1);
    check("R5 buffer unchanged more", more_pending, 1);

    remove(2'd1, 4'd1);
    query(2'd1, 1'b0, 4'd0);
    check("R4 head removed", nxt_tag, 2);

    // R8: fill bank 2 and offer one more
    push(2'd2, 4'd8, 4'd1);
    push(2'd2, 4'd9, 4'd2);
    push(2'd2, 4'd10, 4'd1);
    push(2'd2, 4'd11, 4'd2);
    @(negedge clk);
    in_bank = 2'd2; #1;
    check("R8 in_ready low on full bank", in_ready, 0);
    in_bank = 2'd0; #1;
    check("R8 other bank ready", in_ready, 1);
    push(2'd2, 4'd15, 4'd9);
    remove(2'd2, 4'd8);
    query(2'd2, 1'b1, 4'd9);
    check("R8 refused request absent", nxt_tag, 9);
    check("R8 refused request no hit", hit_ahead, 0);

    // R11: insert and remove together on bank 1 (tag2 r5, tag4 r7)
    @(negedge clk);
    in_valid = 1'b1; in_bank = 2'd1; in_tag = 4'd6; in_row = 4'd5;
    rm_valid = 1'b1; rm_bank = 2'd1; rm_tag = 4'd2;
    @(negedge clk);
    in_valid = 1'b0; rm_valid = 1'b0;
    query(2'd1, 1'b0, 4'd0);
    check("R11 survivor is head", nxt_tag, 4);
    check("R11 two held", more_pending, 1);
    query(2'd1, 1'b1, 4'd5);
    check("R11 new entry at tail", nxt_tag, 6);

    // R6 / R10: drain
    remove(2'd1, 4'd4);
    query(2'd1, 1'b0, 4'd0);
    check("R6 single entry more low", more_pending, 0);
    check("R6 single entry valid", nxt_valid, 1);
    remove(2'd1, 4'd6);
    query(2'd1, 1'b0, 4'd0);
    check("R10 drained bank", nxt_valid, 0);

    // R9: FIFO policy versus open-row-first on bank 3
    push(2'd3, 4'd1, 4'd5);
    push(2'd3, 4'd2, 4'd3);
    push(2'd3, 4'd3, 4'd5);
    query(2'd3, 1'b1, 4'd3);
    check("R9 fifo offers head", f_nxt_tag, 1);
    check("R3 open-row-first offers hit", nxt_tag, 2);
    check("R9 fifo second entry row hit", f_hit, 1);
    query(2'd3, 1'b1, 4'd5);
    check("R9 fifo second entry row miss", f_hit, 0);
    check("R7 two row matches", hit_ahead, 1);
    @(negedge clk);
    rm_valid = 1'b1; rm_bank = 2'd3; rm_tag = 4'd2;
    #1;
    check("R9 fifo non-head removal error", f_rm_err, 1);
    check("R4 any-position removal accepted", rm_err, 0);
    @(negedge clk);
    rm_valid = 1'b0;
    query(2'd3, 1'b0, 4'd0);
    check("R9 fifo head kept", f_nxt_tag, 1);
    remove(2'd3, 4'd1);
    query(2'd3, 1'b0, 4'd0);
    check("R9 fifo pop head", f_nxt_tag, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule